// File: doc/BRIEF.md
# Posted-Write Watchdog Timer

This block is a memory-mapped watchdog counter for a system that runs its bus on a fast clock while the timer runs on a slow tick of about 32 kHz. The slow tick is supplied as a one-cycle clock-enable, `tick_en`. Software sets a reload value and a prescaler. It writes a trigger word to restart the countdown window, and starts or stops the timer only with fixed two-word key sequences. If the counter is allowed to roll over its full range, the block raises `wdog_rst_o` to reset the system.

Each register write is posted. The written word is held in a slot for that register, and a busy flag in the pending-status register stays set until the slot has seen three slow ticks. The write takes effect on that third tick. Software polls the status register before it depends on a write. Reads are registered and return data one cycle after `rd_en`. The live counter can be read at any moment, so software can work out how long remains before a reset.

Register word addresses: control 0, reload 1, counter 2 (read only), trigger 3, key 4 (reads 0), pending status 5 (read only). Other addresses read as 0.

Top module: `wdog_posted`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the timer is stopped, no write is pending and `wdog_rst_o` is low.
- R2: A write sets the busy bit of its register in the pending-status register at address 5. The bits are: bit 0 for control, bit 2 for reload, bit 3 for trigger, bit 4 for key. The bit stays set through the first two slow ticks after the write and clears on the third tick, which is when the write takes effect. A new write to a busy register replaces its data and restarts the three-tick wait.
- R3: The timer starts only when the key register takes 0x0000BBBB and then 0x00004444.
- R4: The timer stops only when the key register takes 0x0000AAAA and then 0x00005555.
- R5: Any other key word, including a wrong second word, discards a pending first word and leaves the run state unchanged.
- R6: A trigger write copies the reload value into the counter only if the written word differs from the previous trigger word. A repeated word has no effect on the counter.
- R7: While running, the counter increments once per slow tick when control bit 5 is 0. When bit 5 is 1, it increments once every 2^n ticks, where n is control bits 4:2.
- R8: Writes to the control and reload registers are discarded if they mature while the timer is running.
- R9: The counter at address 2 can be read at any time, and it holds its value while the timer is stopped.
- R10: When a running counter steps past 0xFFFFFFFF, it is reloaded from the reload register and `wdog_rst_o` is high for exactly one prescaled step.
- R11: A read returns the addressed register on `rdata` in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable marking each slow tick |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The key register is driven with the correct start pair, with a start word followed by a wrong word and then the correct second word, and with the stop pair. This separates a design that enforces the sequence from one that reacts to a single word. Counting is measured as the difference between two reads taken an exact number of ticks apart. This is done with the prescaler off and with it set to divide by four, so a wrong divide ratio shows up as a wrong difference. Trigger words are sent as a new value, then a repeated value after the reload register has changed, then a new value again, which shows whether reloads are gated on a change of word. A start from just below the top of the count range checks the width of the reset pulse and that the counter reloads after the wrap.

// File: rtl/wdog_pkg.sv
// Package: shared addresses, key words and status bit positions for the
// posted-write watchdog. Assumes word addressing on a 3-bit address bus.
package wdog_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int NUM_SLOTS = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_COUNT = 3'd2,
        A_TRIG  = 3'd3,
        A_KEY   = 3'd4,
        A_PEND  = 3'd5
    } reg_addr_e;

    // slot indices for the posted registers
    localparam int SL_CTRL = 0;
    localparam int SL_LOAD = 1;
    localparam int SL_TRIG = 2;
    localparam int SL_KEY  = 3;

    localparam logic [DATA_W-1:0] KEY_RUN_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_RUN_B  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT_B = 32'h0000_5555;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_003C;
    localparam int CTRL_PRE_EN  = 5;
    localparam int CTRL_EXP_LSB = 2;
    localparam int CTRL_EXP_W   = 3;

    // bus address that feeds each posted slot
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            SL_CTRL: slot_addr = A_CTRL;
            SL_LOAD: slot_addr = A_LOAD;
            SL_TRIG: slot_addr = A_TRIG;
            default: slot_addr = A_KEY;
        endcase
    endfunction

    // status-register bit that reports each slot as busy
    function automatic int slot_pend_bit(input int idx);
        case (idx)
            SL_CTRL: slot_pend_bit = 0;
            SL_LOAD: slot_pend_bit = 2;
            SL_TRIG: slot_pend_bit = 3;
            default: slot_pend_bit = 4;
        endcase
    endfunction
endpackage

// File: rtl/wdog_post_slot.sv
// Posted-write slot: holds one register write until POST_TICKS slow ticks
// have passed, then pulses commit_o for one cycle with the held data.
// Assumes tick_en is a one-cycle enable. A write in the same cycle as a
// tick wins, and that tick is not counted.
module wdog_post_slot #(
    parameter int DATA_W     = 32,
    parameter int POST_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CW = $clog2(POST_TICKS + 1);

    logic [CW-1:0] left_q;

    assign commit_o = busy_o && tick_en && !wr_i && (left_q == CW'(1));

    // capture a write, then count slow ticks down to the commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            left_q <= '0;
            data_o <= '0;
        end else if (wr_i) begin
            busy_o <= 1'b1;
            left_q <= CW'(POST_TICKS);
            data_o <= wdata_i;
        end else if (commit_o) begin
            busy_o <= 1'b0;
            left_q <= '0;
        end else if (busy_o && tick_en) begin
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/wdog_key_seq.sv
// Key sequencer: follows committed key words and sets or clears the run
// flag only after a complete start or stop pair. Assumes each word arrives
// as a one-cycle commit pulse.
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] key_i,
    output logic              run_o
);
    typedef enum logic [1:0] {K_IDLE, K_ARM_RUN, K_ARM_HALT} kstate_e;

    kstate_e st_q;

    // advance the key state and update the run flag on each committed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= K_IDLE;
            run_o <= 1'b0;
        end else if (commit_i) begin
            if (key_i == KEY_RUN_A) begin
                st_q <= K_ARM_RUN;
            end else if (key_i == KEY_HALT_A) begin
                st_q <= K_ARM_HALT;
            end else begin
                st_q <= K_IDLE;
                if (st_q == K_ARM_RUN && key_i == KEY_RUN_B)
                    run_o <= 1'b1;
                else if (st_q == K_ARM_HALT && key_i == KEY_HALT_B)
                    run_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Up-counter with power-of-two prescaler and overflow reset pulse. It steps
// on slow ticks while running. A wrap past all-ones reloads from load_i and
// holds rst_o high until the next step. reload_i takes priority over a step.
module wdog_counter #(
    parameter int CNT_W = 32,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [EXP_W-1:0] pre_exp_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_o
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_max;
    logic             step;

    assign pre_max = (PRE_W'(1) << pre_exp_i) - PRE_W'(1);
    assign step    = run_i && tick_en && (!pre_en_i || pre_q == pre_max);

    // prescaler: counts ticks between counter steps
    always_ff @(posedge clk) begin
        if (!rst_n || reload_i || !run_i || !pre_en_i) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= step ? '0 : pre_q + PRE_W'(1);
        end
    end

    // main counter: reload, increment, or wrap to reload value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (reload_i) begin
            count_o <= load_i;
        end else if (step) begin
            count_o <= (&count_o) ? load_i : count_o + CNT_W'(1);
        end
    end

    // reset pulse: raised on the wrapping step, dropped on the next one
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            rst_o <= 1'b0;
        end else if (step) begin
            rst_o <= &count_o;
        end
    end
endmodule

// File: rtl/wdog_posted.sv
// Top: posted-write watchdog timer. Decodes the register bus, posts each
// writable register through its own slot, and applies matured writes.
// Control and reload writes are discarded while running, and a trigger
// reloads only on a new word. Reads are registered (one-cycle latency).
module wdog_posted
    import wdog_pkg::*;
#(
    parameter int POST_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdog_rst_o
);
    logic [NUM_SLOTS-1:0] slot_busy;
    logic [NUM_SLOTS-1:0] slot_commit;
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] trig_q;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] pend_word;
    logic              run;
    logic              reload;

    // one posted slot per writable register
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        wdog_post_slot #(
            .DATA_W    (DATA_W),
            .POST_TICKS(POST_TICKS)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wr_i    (wr_en && (addr == slot_addr(i))),
            .wdata_i (wdata),
            .busy_o  (slot_busy[i]),
            .commit_o(slot_commit[i]),
            .data_o  (slot_data[i])
        );
    end

    // gather the busy flags into their status-register bit positions
    always_comb begin
        pend_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            pend_word[slot_pend_bit(i)] = slot_busy[i];
    end

    assign reload = slot_commit[SL_TRIG] && (slot_data[SL_TRIG] != trig_q);

    // apply matured control, reload and trigger writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (slot_commit[SL_CTRL] && !run)
                ctrl_q <= slot_data[SL_CTRL] & CTRL_MASK;
            if (slot_commit[SL_LOAD] && !run)
                load_q <= slot_data[SL_LOAD];
            if (slot_commit[SL_TRIG])
                trig_q <= slot_data[SL_TRIG];
        end
    end

    wdog_key_seq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(slot_commit[SL_KEY]),
        .key_i   (slot_data[SL_KEY]),
        .run_o   (run)
    );

    wdog_counter #(
        .CNT_W(DATA_W),
        .EXP_W(CTRL_EXP_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_i    (run),
        .pre_en_i (ctrl_q[CTRL_PRE_EN]),
        .pre_exp_i(ctrl_q[CTRL_EXP_LSB +: CTRL_EXP_W]),
        .reload_i (reload),
        .load_i   (load_q),
        .count_o  (count),
        .rst_o    (wdog_rst_o)
    );

    // registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_CTRL:  rdata <= ctrl_q;
                A_LOAD:  rdata <= load_q;
                A_COUNT: rdata <= count;
                A_TRIG:  rdata <= trig_q;
                A_PEND:  rdata <= pend_word;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_posted_chk.sv
// Checker for wdog_posted: temporal properties over its ports and the
// signals passed between its sub-blocks. Attached by bind below.
module wdog_posted_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        busy,
    input logic              run,
    input logic              key_commit,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] count,
    input logic              wdog_rst
);
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LOAD) |=> busy[SL_LOAD]); // R2

    AST_RUN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(key_commit)); // R3

    AST_HALT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(key_commit)); // R4

    AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(load_q)); // R8

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(ctrl_q)); // R8

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> (count == load_q && run)); // R10

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(key_commit) && !run && $past(busy[SL_TRIG]) == 1'b0)
            |-> $stable(count)); // R9
endmodule

bind wdog_posted wdog_posted_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .busy      (slot_busy),
    .run       (run),
    .key_commit(slot_commit[SL_KEY]),
    .ctrl_q    (ctrl_q),
    .load_q    (load_q),
    .count     (count),
    .wdog_rst  (wdog_rst_o)
);

// File: tb/wdog_posted_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// with rdata when the read returns. Differences and pulse widths are checked
// directly.
module wdog_posted_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdog_rst_o;

    int errors = 0;
    int checks = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;
    logic [1:0]  div = '0;

    wdog_posted uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .wdog_rst_o(wdog_rst_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // slow tick: one cycle high in every TICK_DIV, changed on falling edges
    always @(negedge clk) div <= rst_n ? div + 2'd1 : 2'd0;
    assign tick_en = (div == 2'(TICK_DIV - 1));

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: pop and compare each returned read
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic wr_post(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        wait_ticks(4);
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_raw(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog on the bench itself
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v1, v2;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state, read latency
        rd_exp(3'd0, 32'h0, "R1 ctrl");
        rd_exp(3'd1, 32'h0, "R1 load");
        rd_exp(3'd2, 32'h0, "R1 count");
        rd_exp(3'd5, 32'h0, "R1 pend");
        check("R1 wdog_rst", {31'b0, wdog_rst_o}, 32'h0);
        rd_exp(3'd4, 32'h0, "R11 key reads zero");

        // R2: reload write posted, bit 2 busy through two ticks
        wr(3'd1, 32'h100);
        rd_exp(3'd1, 32'h0, "R2 load not yet applied");
        repeat (6) @(negedge clk);
        rd_exp(3'd5, 32'h4, "R2 load busy after two ticks");
        wait_ticks(4);
        rd_exp(3'd5, 32'h0, "R2 load busy cleared");
        rd_exp(3'd1, 32'h100, "R2 load applied");
        wr(3'd0, 32'h0);
        rd_exp(3'd5, 32'h1, "R2 ctrl busy bit0");
        wait_ticks(4);
        wr(3'd4, 32'h0);
        rd_exp(3'd5, 32'h10, "R2 key busy bit4");
        wait_ticks(4);

        // R6: trigger reloads on a new word only
        wr(3'd3, 32'h1);
        rd_exp(3'd5, 32'h8, "R2 trig busy bit3");
        wait_ticks(4);
        rd_exp(3'd2, 32'h100, "R6 trigger reload");
        wr_post(3'd1, 32'h200);
        wr_post(3'd3, 32'h1);
        rd_exp(3'd2, 32'h100, "R6 repeated trigger ignored");
        wr_post(3'd3, 32'h2);
        rd_exp(3'd2, 32'h200, "R6 new trigger reloads");

        // R9: stopped counter holds
        wait_ticks(5);
        rd_exp(3'd2, 32'h200, "R9 stopped counter holds");

        // R5: wrong second word discards the first
        wr_post(3'd4, 32'h0000_BBBB);
        wr_post(3'd4, 32'h0000_1234);
        wr_post(3'd4, 32'h0000_4444);
        wait_ticks(3);
        rd_exp(3'd2, 32'h200, "R5 broken start sequence");

        // R3 / R7: start, count one per tick
        wr_post(3'd4, 32'h0000_BBBB);
        wr_post(3'd4, 32'h0000_4444);
        rd_raw(3'd2, v1);
        repeat (10 * TICK_DIV - 1) @(negedge clk);
        rd_raw(3'd2, v2);
        check("R3/R7 running, one step per tick", v2 - v1, 32'd10);

        // R8: control and reload frozen while running
        wr_post(3'd1, 32'h999);
        wr_post(3'd0, 32'h28);
        rd_exp(3'd1, 32'h200, "R8 load write ignored");
        rd_exp(3'd0, 32'h0, "R8 ctrl write ignored");

        // R4: stop pair freezes counter
        wr_post(3'd4, 32'h0000_AAAA);
        wr_post(3'd4, 32'h0000_5555);
        rd_raw(3'd2, v1);
        wait_ticks(6);
        rd_raw(3'd2, v2);
        check("R4 stopped, counter frozen", v2 - v1, 32'd0);

        // R7: prescaler divide by 4 (bit5, exponent 2)
        wr_post(3'd0, 32'h28);
        rd_exp(3'd0, 32'h28, "R7 ctrl applied when stopped");
        wr_post(3'd4, 32'h0000_BBBB);
        wr_post(3'd4, 32'h0000_4444);
        rd_raw(3'd2, v1);
        repeat (16 * TICK_DIV - 1) @(negedge clk);
        rd_raw(3'd2, v2);
        check("R7 prescaled step count", v2 - v1, 32'd4);
        wr_post(3'd4, 32'h0000_AAAA);
        wr_post(3'd4, 32'h0000_5555);

        // R10: wrap near the top of the range
        wr_post(3'd0, 32'h0);
        wr_post(3'd1, 32'hFFFF_FFFE);
        wr_post(3'd3, 32'h3);
        rd_exp(3'd2, 32'hFFFF_FFFE, "R10 preload");
        check("R10 no reset while stopped", {31'b0, wdog_rst_o}, 32'h0);
        wr_post(3'd4, 32'h0000_BBBB);
        wr(3'd4, 32'h0000_4444);
        hi = 0;
        for (int i = 0; i < 200 && !wdog_rst_o; i++) @(negedge clk);
        while (wdog_rst_o && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check("R10 reset pulse width in cycles", hi, TICK_DIV);
        rd_exp(3'd2, 32'hFFFF_FFFF, "R10 counter reloaded after wrap");

        @(negedge clk);
        finish_run();
    end
endmodule